// File: doc/BRIEF.md
# Integer Add/Subtract Unit with Status Flag Update

This block is the combinational arithmetic stage of a small CPU that works on register-register and register-immediate forms. It takes the destination operand and either a source register or an immediate. It forms a sum or a difference, or an increment by one or by four, and it drives the result and a write strobe for the register file. It also drives the next value of the processor status word. Within that word, four low bits hold the zero, negative, carry and overflow flags.

Two inputs decide whether the flags change: the operation and the class of the destination register (data, address or stack pointer). The immediate comes from the raw instruction bits. Short forms are sign-extended. The long form is built from two half-words. Register storage and instruction decode sit outside this block. The decoder supplies the codes listed below.

Top module: `alu_flags`

## Requirements
- R1: The source operand is selected by `imm_size_i`. Code 0 takes `b_i`. Code 1 sign-extends `imm_hi_i[7:0]`. Code 2 sign-extends `imm_hi_i[15:0]`. Code 3 forms `{imm_hi_i, imm_ext_i}`, with `imm_hi_i` as the upper half.
- R2: Add (`op_i`=0) gives `a_i + src`. C is the carry out of bit 31. V is set when both operands have the same sign and the result sign differs from it.
- R3: Add-with-carry (`op_i`=1) adds `psw_i[2]` as the carry-in. C and V come from the full computation, including that carry-in.
- R4: Subtract (`op_i`=2) gives `a_i - src`. C is set when `src` is unsigned-greater than `a_i`. V is set when the operand signs differ and the result sign differs from the sign of `a_i`.
- R5: Subtract-with-borrow (`op_i`=3) also subtracts `psw_i[2]`. C is the borrow of the full computation, so it is set when `a_i < src + borrow`.
- R6: Compare (`op_i`=4) drives the same result and flags as subtract, and `wr_en_o` stays low.
- R7: On every flag update, Z (`psw_o[0]`) is set exactly when the 32-bit result is zero, and N (`psw_o[1]`) equals result bit 31.
- R8: Increment (`op_i`=5) gives `a_i + 1` with add-style flags. Increment-by-four (`op_i`=6) gives `a_i + 4`. Both ignore `b_i` and the immediate.
- R9: `psw_o` equals `psw_i` in three cases: the destination is the stack pointer (`dst_cls_i`=2), increment-by-four for any destination, and increment to an address register (`dst_cls_i`=1). Data registers are `dst_cls_i`=0.
- R10: A flag update first clears Z, N, C and V (bits 0..3) and then sets those that apply. `psw_o` bits above bit 3 always equal `psw_i`.
- R11: Operation code 7 and destination class 3 are reserved. Either one drives `result_o`=0 and `wr_en_o`=0, and passes `psw_i` through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | Destination operand (current register value) |
| b_i | input | 32 | Source register operand |
| op_i | input | 3 | Operation code |
| imm_size_i | input | 2 | Source select: register, 8-, 16- or 32-bit immediate |
| imm_hi_i | input | 16 | Immediate bits taken from the instruction word |
| imm_ext_i | input | 16 | Extension half-word, lower half of a 32-bit immediate |
| dst_cls_i | input | 2 | Destination class: data, address, stack pointer |
| psw_i | input | 8 | Current status word |
| result_o | output | 32 | Computed value |
| wr_en_o | output | 1 | Result should be written to the destination |
| psw_o | output | 8 | Next status word |

## Verification
The checker treats the block as settled logic and evaluates its properties only when every input holds a known value. It also expects any status word above the four flag bits to be carried through untouched. The bench therefore drives every input to a defined value in the half cycle away from the sampling point. It walks the full code space of operation, source size and destination class, including the reserved codes, so that no property is evaluated on a value outside the decoded set. The operands come from a fixed set of sign and carry boundary values. The incoming status word switches between a pattern with every low flag clear and a pattern with all of them set, so that stale flags would show.

// File: rtl/alu_flags.sv
module alu_flags #(
  parameter int WIDTH = 32,
  parameter int PSW_W = 8
) (
  input  logic [WIDTH-1:0]   a_i,
  input  logic [WIDTH-1:0]   b_i,
  input  logic [2:0]         op_i,
  input  logic [1:0]         imm_size_i,
  input  logic [WIDTH/2-1:0] imm_hi_i,
  input  logic [WIDTH/2-1:0] imm_ext_i,
  input  logic [1:0]         dst_cls_i,
  input  logic [PSW_W-1:0]   psw_i,
  output logic [WIDTH-1:0]   result_o,
  output logic               wr_en_o,
  output logic [PSW_W-1:0]   psw_o
);
  localparam int MSB   = WIDTH - 1;
  localparam int HALF  = WIDTH / 2;
  localparam int QUART = WIDTH / 4;
  localparam int ZB = 0, NB = 1, CB = 2, VB = 3;

  localparam logic [2:0] OP_ADD = 3'd0, OP_ADDC = 3'd1, OP_SUB = 3'd2, OP_SUBB = 3'd3,
                         OP_CMP = 3'd4, OP_INC = 3'd5, OP_INC4 = 3'd6, OP_RSVD = 3'd7;
  localparam logic [1:0] DST_DATA = 2'd0, DST_ADDR = 2'd1, DST_SP = 2'd2, DST_RSVD = 2'd3;

  logic [MSB:0] imm_val, src, res;
  logic [WIDTH:0] wide;
  logic is_sub, cin, carry, ovf, valid, upd;

  always_comb begin
    case (imm_size_i)
      2'd1:    imm_val = {{(WIDTH-QUART){imm_hi_i[QUART-1]}}, imm_hi_i[QUART-1:0]};
      2'd2:    imm_val = {{HALF{imm_hi_i[HALF-1]}}, imm_hi_i};
      2'd3:    imm_val = {imm_hi_i, imm_ext_i};
      default: imm_val = b_i;
    endcase
  end

  always_comb begin
    case (op_i)
      OP_INC:  src = WIDTH'(1);
      OP_INC4: src = WIDTH'(4);
      default: src = imm_val;
    endcase
  end

  assign is_sub = (op_i == OP_SUB) || (op_i == OP_SUBB) || (op_i == OP_CMP);
  assign cin    = ((op_i == OP_ADDC) || (op_i == OP_SUBB)) && psw_i[CB];

  assign wide  = is_sub ? ({1'b0, a_i} - {1'b0, src} - (WIDTH+1)'(cin))
                        : ({1'b0, a_i} + {1'b0, src} + (WIDTH+1)'(cin));
  assign res   = wide[MSB:0];
  assign carry = wide[WIDTH];
  assign ovf   = is_sub ? ((a_i[MSB] != src[MSB]) && (res[MSB] != a_i[MSB]))
                        : ((a_i[MSB] == src[MSB]) && (res[MSB] != a_i[MSB]));

  assign valid = (op_i != OP_RSVD) && (dst_cls_i != DST_RSVD);
  assign upd   = valid && (dst_cls_i != DST_SP) && (op_i != OP_INC4) &&
                 !((op_i == OP_INC) && (dst_cls_i == DST_ADDR));

  assign result_o = valid ? res : '0;
  assign wr_en_o  = valid && (op_i != OP_CMP);

  always_comb begin
    psw_o = psw_i;
    if (upd) begin
      psw_o[ZB] = (res == '0);
      psw_o[NB] = res[MSB];
      psw_o[CB] = carry;
      psw_o[VB] = ovf;
    end
  end

  logic unused_dst;
  assign unused_dst = (dst_cls_i == DST_DATA) && (op_i == OP_ADD);
endmodule

// File: rtl/alu_flags_chk.sv
module alu_flags_chk #(
  parameter int WIDTH = 32,
  parameter int PSW_W = 8
) (
  input logic [WIDTH-1:0]   a_i,
  input logic [WIDTH-1:0]   b_i,
  input logic [2:0]         op_i,
  input logic [1:0]         imm_size_i,
  input logic [WIDTH/2-1:0] imm_hi_i,
  input logic [WIDTH/2-1:0] imm_ext_i,
  input logic [1:0]         dst_cls_i,
  input logic [PSW_W-1:0]   psw_i,
  input logic [WIDTH-1:0]   result_o,
  input logic               wr_en_o,
  input logic [PSW_W-1:0]   psw_o
);
  logic known, rsvd, held, flags_on;
  assign known = !$isunknown({a_i, b_i, op_i, imm_size_i, imm_hi_i, imm_ext_i, dst_cls_i, psw_i});
  assign rsvd  = (op_i == 3'd7) || (dst_cls_i == 2'd3);
  assign held  = (dst_cls_i == 2'd2) || (op_i == 3'd6) || ((op_i == 3'd5) && (dst_cls_i == 2'd1));
  assign flags_on = !rsvd && !held;

  always_comb begin
    if (known) begin
      AST_CMP_NO_WRITE: assert (!(op_i == 3'd4) || !wr_en_o);                        // R6
      AST_FLAGS_HELD:   assert (!held || (psw_o == psw_i));                          // R9
      AST_UPPER_KEPT:   assert (psw_o[PSW_W-1:4] == psw_i[PSW_W-1:4]);               // R10
      AST_ZERO_FLAG:    assert (!flags_on || (psw_o[0] == (result_o == '0)));        // R7
      AST_NEG_FLAG:     assert (!flags_on || (psw_o[1] == result_o[WIDTH-1]));       // R7
      AST_RESERVED:     assert (!rsvd || (!wr_en_o && result_o == '0 && psw_o == psw_i)); // R11
      AST_INC4_VALUE:   assert (!(op_i == 3'd6 && !rsvd) || (result_o == a_i + WIDTH'(4))); // R8
    end
  end
endmodule

bind alu_flags alu_flags_chk #(.WIDTH(WIDTH), .PSW_W(PSW_W)) u_chk (
  .a_i(a_i), .b_i(b_i), .op_i(op_i), .imm_size_i(imm_size_i), .imm_hi_i(imm_hi_i),
  .imm_ext_i(imm_ext_i), .dst_cls_i(dst_cls_i), .psw_i(psw_i),
  .result_o(result_o), .wr_en_o(wr_en_o), .psw_o(psw_o)
);

// File: tb/test_alu_flags.sv
module test_alu_flags;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] a = '0, b = '0;
  logic [2:0]  op = '0;
  logic [1:0]  sz = '0, dst = '0;
  logic [15:0] ih = '0, ie = '0;
  logic [7:0]  psw = '0;
  logic [31:0] res;
  logic        wr;
  logic [7:0]  pswo;

  int checks = 0;
  int errors = 0;

  alu_flags i_alu_flags (
    .a_i(a), .b_i(b), .op_i(op), .imm_size_i(sz), .imm_hi_i(ih), .imm_ext_i(ie),
    .dst_cls_i(dst), .psw_i(psw), .result_o(res), .wr_en_o(wr), .psw_o(pswo)
  );

  logic [31:0] vals [10] = '{32'h0000_0000, 32'h0000_0001, 32'h0000_0004, 32'h7FFF_FFFF,
                             32'h8000_0000, 32'h8000_0001, 32'hFFFF_FFFC, 32'hFFFF_FFFF,
                             32'h1234_5678, 32'h00FF_8080};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s op=%0d sz=%0d dst=%0d a=%h b=%h psw=%h act=%h exp=%h",
               tag, op, sz, dst, a, b, psw, act, exp);
    end
  endtask

  task automatic model(output logic [31:0] er, output logic ew, output logic [7:0] ep,
                       output string rtag, output string ftag);
    logic [31:0] s, r;
    longint unsigned w;
    logic c, v, valid, upd, sub;
    bit cin;
    case (sz)
      2'd1: s = {{24{ih[7]}}, ih[7:0]};
      2'd2: s = {{16{ih[15]}}, ih};
      2'd3: s = {ih, ie};
      default: s = b;
    endcase
    if (op == 3'd5) s = 32'd1;
    if (op == 3'd6) s = 32'd4;
    sub = (op == 3'd2) || (op == 3'd3) || (op == 3'd4);
    cin = ((op == 3'd1) || (op == 3'd3)) && psw[2];
    if (sub) begin
      w = longint'(a) - longint'(s) - longint'(cin);
      c = (longint'(a) < longint'(s) + longint'(cin));
    end else begin
      w = longint'(a) + longint'(s) + longint'(cin);
      c = w[32];
    end
    r = w[31:0];
    v = sub ? ((a[31] != s[31]) && (r[31] != a[31])) : ((a[31] == s[31]) && (r[31] != a[31]));
    valid = (op != 3'd7) && (dst != 2'd3);
    upd = valid && dst != 2'd2 && op != 3'd6 && !(op == 3'd5 && dst == 2'd1);
    er = valid ? r : 32'h0;
    ew = valid && op != 3'd4;
    ep = upd ? {psw[7:4], v, c, r[31], (r == 32'h0)} : psw;
    case (op)
      3'd0: ftag = "R2";
      3'd1: ftag = "R3";
      3'd2: ftag = "R4";
      3'd3: ftag = "R5";
      3'd4: ftag = "R6";
      default: ftag = "R8";
    endcase
    rtag = (sz != 0 && op < 3'd5) ? "R1" : ftag;
    if (!valid) begin rtag = "R11"; ftag = "R11"; end
    else if (!upd) ftag = "R9";
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] er;
    logic ew;
    logic [7:0] ep;
    string rtag, ftag;
    repeat (3) @(negedge clk);
    #2;
    chk("R7 reset", res, 32'h0);
    chk("R7 reset", {31'h0, wr}, 32'h1);
    chk("R7 reset", {24'h0, pswo}, 32'h1);
    @(negedge clk);
    rst_n = 1'b1;
    for (int o = 0; o < 8; o++)
      for (int d = 0; d < 4; d++)
        for (int z = 0; z < 4; z++)
          for (int cb = 0; cb < 2; cb++)
            for (int ia = 0; ia < 10; ia++)
              for (int ib = 0; ib < 10; ib++) begin
                @(negedge clk);
                op = 3'(o); dst = 2'(d); sz = 2'(z);
                psw = cb ? 8'h5F : 8'hA0;
                a = vals[ia]; b = vals[ib];
                ih = vals[ib][15:0]; ie = vals[(ib + 3) % 10][31:16];
                #2;
                model(er, ew, ep, rtag, ftag);
                chk(rtag, res, er);
                chk(op == 3'd4 ? "R6" : rtag, {31'h0, wr}, {31'h0, ew});
                chk(ftag == "R9" || ftag == "R11" ? ftag : "R7", {30'h0, pswo[1:0]}, {30'h0, ep[1:0]});
                chk(ftag, {30'h0, pswo[3:2]}, {30'h0, ep[3:2]});
                chk("R10", {28'h0, pswo[7:4]}, {28'h0, ep[7:4]});
              end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule